// File: doc/BRIEF.md
# Wide-to-Variable Byte Gearbox

The gearbox turns a stream of wide words into short byte chunks whose length the consumer picks each cycle. A producer hands it 256-bit words through a valid/ready handshake. A sampling core downstream asks for between 3 and 6 bytes per cycle and takes them through a second valid/ready handshake. The bytes come out in stream order. A chunk that starts near the end of one word and continues into the next comes out whole in a single cycle.

Two word slots hold the current word and the one after it. A byte pointer marks the first unread byte of the current word. The chunk is picked out of the two-slot window by a per-byte multiplexer driven by the pointer, so no multi-ported byte memory is needed. When a chunk uses the last byte of the current word, that word is retired and the next word moves up. In the same cycle, a fresh input word can be taken into the slot this frees.

Top module: `byte_gearbox`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: Stream byte `32*w+b` is bits `[8b+7:8b]` of the w-th accepted input word. While `out_valid_o` is high, byte k of `out_data_o` (bits `[8k+7:8k]`) equals stream byte `p+k` for every k below the effective length, where p is the number of bytes consumed so far. Bytes at positions at or above the effective length read as zero.
- R3: `out_valid_o` is high in exactly those cycles in which the number of accepted but unconsumed bytes is at least the effective length.
- R4: Each cycle with both `out_valid_o` and `out_ready_i` high consumes exactly the effective length in bytes. Whenever two words are held, `out_valid_o` is high, so a chunk that crosses a word boundary never stalls.
- R5: `in_ready_o` is high when fewer than two words are held. It is also high when two words are held and the current handshake uses the last byte of the older word, that is, pointer plus effective length is 32 or more.
- R6: Under any pattern of input gaps and output stalls, no byte is lost, repeated or reordered, and the stream keeps moving.
- R7: The effective length is `chunk_len_i` limited to the range 3..6. Codes 0, 1 and 2 act as 3, and code 7 acts as 6.
- R8: While `out_valid_o` is high and `out_ready_i` is low, with `chunk_len_i` unchanged, the next cycle still shows `out_valid_o` high and the same `out_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 256 | Input word; byte 0 is in the low 8 bits |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Gearbox can take the input word |
| chunk_len_i | input | 3 | Requested chunk length in bytes (limited to 3..6) |
| out_data_o | output | 48 | Chunk, byte 0 in the low 8 bits, zero above the length |
| out_valid_o | output | 1 | Enough bytes are buffered for the requested chunk |
| out_ready_i | input | 1 | Consumer takes the chunk this cycle |

## Verification
The hardest cycle is one in which a chunk uses the last byte of the older word, so that word retires, and in that same cycle a new input word is accepted into the slot being freed. The bench provokes this by holding the producer always valid, so both slots stay full. It then runs every chunk length, each legal one and each out-of-range code, so the pointer wraps at every possible offset. It also runs phases with gaps and stalls driven by an LFSR. Each cycle it computes the expected ready and valid from a byte-count model and compares every chunk byte with an arithmetic stream formula. A missed refill or an overwrite of the held word would therefore show up as a wrong ready or a wrong byte.

// File: rtl/gb_pkg.sv
package gb_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic nxt;  // second slot holds a word
    logic cur;  // first slot holds a word
  } slot_vld_t;
endpackage

// File: rtl/gb_ptr_ctrl.sv
module gb_ptr_ctrl #(
  parameter int unsigned WORD_BYTES = 32,
  parameter int unsigned LEN_W      = 3,
  parameter int unsigned MAX_CHUNK  = 6,
  localparam int unsigned PTR_W     = $clog2(WORD_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             retire_o
);
  localparam int unsigned SUM_W = PTR_W + 1;
  localparam logic [SUM_W-1:0] WB_S = SUM_W'(WORD_BYTES);

  logic [PTR_W-1:0] ptr_q;
  logic [SUM_W-1:0] sum;

  assign sum      = SUM_W'(ptr_q) + SUM_W'(len_i);
  assign retire_o = fire_i && (sum >= WB_S);
  assign ptr_o    = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (fire_i) begin
      ptr_q <= retire_o ? PTR_W'(sum - WB_S) : PTR_W'(sum);
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(ptr_q)); // R8
  AST_PTR_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !retire_o) |=> (ptr_q > $past(ptr_q))); // R4
  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> (ptr_q < $past(ptr_q))); // R4
endmodule

// File: rtl/gb_slots.sv
module gb_slots
  import gb_pkg::*;
#(
  parameter int unsigned WORD_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              retire_i,
  output logic [WORD_W-1:0] cur_o,
  output logic [WORD_W-1:0] nxt_o,
  output slot_vld_t         vld_o
);
  logic [WORD_W-1:0] cur_q, nxt_q;
  slot_vld_t         vld_q;
  logic              in_fire;
  logic              cur_after;

  // occupancy of the first slot once a retire has shifted the pair
  assign cur_after  = retire_i ? vld_q.nxt : vld_q.cur;
  assign in_ready_o = !vld_q.nxt || retire_i;
  assign in_fire    = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      nxt_q <= '0;
      vld_q <= '0;
    end else begin
      if (retire_i) begin
        cur_q     <= nxt_q;
        vld_q.cur <= vld_q.nxt;
        vld_q.nxt <= 1'b0;
      end
      if (in_fire) begin
        if (cur_after) begin
          nxt_q     <= in_data_i;
          vld_q.nxt <= 1'b1;
        end else begin
          cur_q     <= in_data_i;
          vld_q.cur <= 1'b1;
        end
      end
    end
  end

  assign cur_o = cur_q;
  assign nxt_o = nxt_q;
  assign vld_o = vld_q;

  AST_SLOT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q.nxt |-> vld_q.cur); // R6
  AST_NXT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q.nxt && !retire_i) |=> (vld_q.nxt && $stable(nxt_q))); // R6
  AST_RETIRE_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && vld_q.nxt) |=> (cur_q == $past(nxt_q))); // R6
endmodule

// File: rtl/gb_shift_mux.sv
module gb_shift_mux
  import gb_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 32,
  parameter int unsigned MAX_CHUNK  = 6,
  parameter int unsigned LEN_W      = 3,
  localparam int unsigned PTR_W     = $clog2(WORD_BYTES),
  localparam int unsigned WIN_W     = 2 * WORD_BYTES * BYTE_W,
  localparam int unsigned OUT_W     = MAX_CHUNK * BYTE_W
) (
  input  logic [WIN_W-1:0] win_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [OUT_W-1:0] chunk_o
);
  localparam int unsigned IDX_W   = $clog2(2 * WORD_BYTES);
  localparam int unsigned REACH   = WORD_BYTES + MAX_CHUNK;

  for (genvar j = 0; j < MAX_CHUNK; j++) begin : g_byte
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] sel;

    assign idx = IDX_W'(ptr_i) + IDX_W'(j);

    always_comb begin
      sel = '0;
      for (int b = 0; b < REACH; b++) begin
        if (idx == IDX_W'(b)) sel = win_i[b*BYTE_W +: BYTE_W];
      end
    end

    assign chunk_o[j*BYTE_W +: BYTE_W] = (LEN_W'(j) < len_i) ? sel : '0;
  end
endmodule

// File: rtl/byte_gearbox.sv
module byte_gearbox
  import gb_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 32,
  parameter int unsigned MIN_CHUNK  = 3,
  parameter int unsigned MAX_CHUNK  = 6,
  localparam int unsigned WORD_W    = WORD_BYTES * BYTE_W,
  localparam int unsigned LEN_W     = $clog2(MAX_CHUNK + 1),
  localparam int unsigned OUT_W     = MAX_CHUNK * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [LEN_W-1:0]  chunk_len_i,
  output logic [OUT_W-1:0]  out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i
);
  localparam int unsigned PTR_W = $clog2(WORD_BYTES);
  localparam int unsigned CNT_W = $clog2(2 * WORD_BYTES + 1);

  logic [LEN_W-1:0]  len_c;
  logic [PTR_W-1:0]  ptr;
  logic              retire;
  logic              out_fire;
  logic [WORD_W-1:0] cur_w, nxt_w;
  slot_vld_t         vld;
  logic [CNT_W-1:0]  avail;

  always_comb begin
    if (chunk_len_i < LEN_W'(MIN_CHUNK))      len_c = LEN_W'(MIN_CHUNK);
    else if (chunk_len_i > LEN_W'(MAX_CHUNK)) len_c = LEN_W'(MAX_CHUNK);
    else                                      len_c = chunk_len_i;
  end

  always_comb begin
    avail = '0;
    if (vld.cur) begin
      avail = CNT_W'(WORD_BYTES) - CNT_W'(ptr);
      if (vld.nxt) avail = avail + CNT_W'(WORD_BYTES);
    end
  end

  assign out_valid_o = (avail >= CNT_W'(len_c));
  assign out_fire    = out_valid_o && out_ready_i;

  gb_ptr_ctrl #(
    .WORD_BYTES(WORD_BYTES),
    .LEN_W     (LEN_W),
    .MAX_CHUNK (MAX_CHUNK)
  ) ptr_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (out_fire),
    .len_i   (len_c),
    .ptr_o   (ptr),
    .retire_o(retire)
  );

  gb_slots #(
    .WORD_W(WORD_W)
  ) slots_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_data_i (in_data_i),
    .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o),
    .retire_i  (retire),
    .cur_o     (cur_w),
    .nxt_o     (nxt_w),
    .vld_o     (vld)
  );

  gb_shift_mux #(
    .WORD_BYTES(WORD_BYTES),
    .MAX_CHUNK (MAX_CHUNK),
    .LEN_W     (LEN_W)
  ) mux_i (
    .win_i  ({nxt_w, cur_w}),
    .ptr_i  (ptr),
    .len_i  (len_c),
    .chunk_o(out_data_o)
  );

  AST_FULL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld.cur && vld.nxt) |-> out_valid_o); // R4
  AST_STALL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o || (len_c != $past(len_c)))); // R8
  AST_STALL_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> ($stable(out_data_o) || (len_c != $past(len_c)))); // R8
  AST_RETIRE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire |-> in_ready_o); // R5
  AST_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld.cur |-> !out_valid_o); // R3
endmodule

// File: tb/byte_gearbox_tb_top.sv
module byte_gearbox_tb_top;
  localparam int unsigned WB    = 32;
  localparam int unsigned WW    = WB * 8;
  localparam longint      LIMIT = 150000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [WW-1:0] in_data_i = '0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [2:0]    chunk_len_i = 3'd3;
  logic [47:0]   out_data_o;
  logic          out_valid_o;
  logic          out_ready_i = 1'b0;

  int     checks = 0;
  int     errors = 0;
  bit     done = 1'b0;
  longint pushed_w = 0;
  longint rd = 0;
  logic [15:0] lfsr = 16'hace1;
  bit          prev_stall = 1'b0;
  logic [2:0]  prev_raw = '0;
  logic [47:0] prev_data = '0;

  always #5 clk_i = ~clk_i;

  byte_gearbox dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_data_i  (in_data_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .chunk_len_i(chunk_len_i),
    .out_data_o (out_data_o),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i)
  );

  function automatic logic [7:0] sb(longint n);
    return 8'((n * 7) + ((n >> 5) * 13) + 1);
  endfunction

  function automatic logic [WW-1:0] word_of(longint w);
    logic [WW-1:0] r;
    for (int b = 0; b < WB; b++) r[b*8 +: 8] = sb(w * WB + b);
    return r;
  endfunction

  function automatic int eff_len(logic [2:0] raw);
    if (raw < 3) return 3;
    if (raw > 6) return 6;
    return int'(raw);
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // in_mode/out_mode: 0 always, 1 half, 2 sparse; len_mode 0..7 fixed code, 8 legal mix, 9 any code
  task automatic run_phase(int cycles, int in_mode, int out_mode, int len_mode);
    longint rd_start = rd;
    for (int c = 0; c < cycles; c++) begin
      int          eff;
      longint      held;
      longint      avail;
      bit          exp_valid;
      bit          exp_ready;
      logic [47:0] exp_data;
      @(negedge clk_i);
      step_lfsr();
      in_valid_i  = (in_mode == 0) ? 1'b1 : (in_mode == 1) ? lfsr[0] : (lfsr[2:0] == 3'd0);
      out_ready_i = (out_mode == 0) ? 1'b1 : (out_mode == 1) ? lfsr[5] : (lfsr[8:6] == 3'd0);
      if (len_mode < 8)       chunk_len_i = 3'(len_mode);
      else if (len_mode == 8) chunk_len_i = 3'd3 + {1'b0, lfsr[11:10]};
      else                    chunk_len_i = lfsr[14:12];
      in_data_i = word_of(pushed_w);
      #1;
      eff       = eff_len(chunk_len_i);
      held      = pushed_w - rd / WB;
      avail     = pushed_w * WB - rd;
      exp_valid = (avail >= eff);
      check(out_valid_o == exp_valid, "R3 out_valid", 64'(out_valid_o), 64'(exp_valid));
      if (held == 2) check(out_valid_o == 1'b1, "R4 two words held", 64'(out_valid_o), 64'd1);
      exp_ready = (held < 2) || (exp_valid && out_ready_i && ((rd % WB) + eff >= WB));
      check(in_ready_o == exp_ready, "R5 in_ready", 64'(in_ready_o), 64'(exp_ready));
      if (exp_valid) begin
        exp_data = '0;
        for (int k = 0; k < eff; k++) exp_data[k*8 +: 8] = sb(rd + k);
        if (chunk_len_i < 3 || chunk_len_i > 6)
          check(out_data_o == exp_data, "R7 clamped chunk", 64'(out_data_o), 64'(exp_data));
        else
          check(out_data_o == exp_data, "R2 chunk bytes", 64'(out_data_o), 64'(exp_data));
      end
      if (prev_stall && prev_raw == chunk_len_i) begin
        check(out_valid_o == 1'b1, "R8 stall valid", 64'(out_valid_o), 64'd1);
        check(out_data_o == prev_data, "R8 stall data", 64'(out_data_o), 64'(prev_data));
      end
      prev_stall = out_valid_o && !out_ready_i;
      prev_raw   = chunk_len_i;
      prev_data  = out_data_o;
      if (in_valid_i && in_ready_o) pushed_w++;
      if (out_valid_o && out_ready_i) rd += eff;
    end
    check(rd > rd_start, "R6 stream progress", 64'(rd - rd_start), 64'd1);
  endtask

  initial begin
    #(LIMIT * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    check(out_valid_o == 1'b0, "R1 valid in reset", 64'(out_valid_o), 64'd0);
    check(in_ready_o == 1'b1, "R1 ready in reset", 64'(in_ready_o), 64'd1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(out_valid_o == 1'b0, "R1 valid after reset", 64'(out_valid_o), 64'd0);
    check(in_ready_o == 1'b1, "R1 ready after reset", 64'(in_ready_o), 64'd1);

    // producer always valid keeps both slots full: retire and refill share a cycle
    for (int l = 3; l <= 6; l++) run_phase(300, 0, 0, l);
    run_phase(150, 0, 0, 0);  // R7
    run_phase(150, 0, 0, 1);  // R7
    run_phase(150, 0, 0, 2);  // R7
    run_phase(150, 0, 0, 7);  // R7
    run_phase(600, 1, 1, 8);  // R6
    run_phase(500, 2, 0, 8);  // R3 starved
    run_phase(500, 0, 2, 9);  // R8 stalled
    run_phase(600, 1, 1, 9);  // R6
    check(rd <= pushed_w * WB, "R6 byte accounting", 64'(rd), 64'(pushed_w * WB));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule